// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the controller side of a two-bank single-data-rate SDRAM. It handles the memory's start-up sequence. When reset is released it holds a quiet command bus with the clock enable high and the byte masks high for a settling period that the integrator chooses. It then precharges every bank and runs a burst of auto-refresh commands. Last, it writes the mode register and announces that the memory is ready for traffic.

After it raises ready, the block paces refreshes at a fixed interval. Sixty-four milliseconds divided among 4096 refreshes gives about 15.6 µs, which is 1950 clocks at the default rate. Each interval end raises a pending request that stays up until the request is served. A refresh is only driven onto the command bus in a cycle where the read/write scheduler reports both banks idle. After each refresh the block holds a busy flag for the row-cycle wait, and the scheduler must keep its own commands off the bus during that time. All timing figures and the mode word are parameters, given in clock cycles.

Top module: `sdr_powerup_refresh`

## Requirements
- R1: While reset is held, the block drives NOP (cmd_o = {cs_n,ras_n,cas_n,we_n} = 4'b0111) with cke_o high and dqm_o all ones. During reset, ready_o, ref_req_o and ref_busy_o are low.
- R2: The precharge-all command (cmd_o = 4'b0010 with addr_o bit AP_BIT, bit 10 by default, set) appears at the STABLE_CYC-th rising edge after reset release. At every edge before that, cmd_o stays NOP and dqm_o stays all ones.
- R3: The first auto-refresh (cmd_o = 4'b0001) appears exactly TRP_CYC edges after the precharge-all, with only NOP between them.
- R4: Initialization issues exactly INIT_REFS auto-refresh commands, and INIT_REFS is at least 2. Each one after the first appears exactly TRC_CYC edges after the previous one, with only NOP between them.
- R5: The mode register load (cmd_o = 4'b0000) appears TRC_CYC edges after the last initialization refresh. It carries MODE_WORD on addr_o and 0 on ba_o.
- R6: ready_o rises exactly TRSC_CYC edges after the mode register load and then stays high. dqm_o is all zeros while ready_o is high. idle_i has no effect on any output before ready_o rises.
- R7: ref_req_o rises REF_INTERVAL edges after ready_o rises. It rises again every REF_INTERVAL edges after that, whenever the earlier requests were served.
- R8: Once it is raised, ref_req_o stays high and no refresh is issued for as long as idle_i is low.
- R9: A runtime refresh (cmd_o = 4'b0001) is issued at the first edge where a request is pending and idle_i is high. ref_req_o clears on that edge. ref_busy_o is high for the following TRC_CYC-1 samples and low after the TRC_CYC-th edge, with NOP on the bus meanwhile.
- R10: If a refresh is granted on the same edge as a new interval end, ref_req_o stays high and the next grant serves the new request.
- R11: With no request pending, a high idle_i issues no refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_i | input | 1 | Scheduler reports both banks idle; permits a refresh grant |
| cmd_o | output | 4 | Registered {cs_n, ras_n, cas_n, we_n} command bundle |
| addr_o | output | ADDR_W | Registered address bus (precharge-all flag, mode word) |
| ba_o | output | 1 | Registered bank select, 0 for every command issued here |
| cke_o | output | 1 | Clock enable to the memory, held high |
| dqm_o | output | DQM_W | Byte masks, high until ready |
| ready_o | output | 1 | Initialization finished; memory accepts traffic |
| ref_req_o | output | 1 | A periodic refresh is pending |
| ref_busy_o | output | 1 | Row-cycle wait after a runtime refresh; scheduler stays off the bus |

## Verification
Two functions can land on the same clock edge: the pacer ending an interval, and the sequencer granting an earlier pending refresh. The bench holds idle_i low across a whole interval, so the old request is still pending when the next interval ends, and it raises idle_i in the cycle just before that edge. The collision is judged correct when a refresh command appears on that edge and ref_req_o stays high. The bench then checks that a later grant issues a second refresh and clears the request.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

   // Command bundle {cs_n, ras_n, cas_n, we_n}
   typedef logic [3:0] sdr_cmd_t;

   localparam sdr_cmd_t CMD_NOP = 4'b0111;
   localparam sdr_cmd_t CMD_PRE = 4'b0010;
   localparam sdr_cmd_t CMD_REF = 4'b0001;
   localparam sdr_cmd_t CMD_MRS = 4'b0000;

   typedef enum logic [2:0] {
      ST_SETTLE,
      ST_TRP,
      ST_TRC_INIT,
      ST_TRSC,
      ST_RUN,
      ST_TRC_RUN
   } seq_state_t;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] limit,
   output logic             expire
);

   logic [CNT_W-1:0] cnt_q;

   // expire marks the limit-th edge after the last restart
   assign expire = (cnt_q == (limit - CNT_W'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/sdr_refresh_pacer.sv
module sdr_refresh_pacer #(
   parameter int unsigned REF_INTERVAL = 1950
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic grant,
   output logic pending
);

   localparam int unsigned IW = $clog2(REF_INTERVAL + 1);

   logic [IW-1:0] cnt_q;
   logic          pend_q;
   logic          tick;

   assign tick    = en && (cnt_q == IW'(REF_INTERVAL - 1));
   assign pending = pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (en) begin
         cnt_q <= tick ? '0 : cnt_q + IW'(1);
      end
   end

   // a fresh interval end wins over a grant that lands on the same edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (tick) begin
         pend_q <= 1'b1;
      end else if (grant) begin
         pend_q <= 1'b0;
      end
   end

endmodule

// File: rtl/sdr_cmd_reg.sv
module sdr_cmd_reg
   import sdr_seq_pkg::*;
#(
   parameter int unsigned ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sdr_cmd_t          cmd_d,
   input  logic [ADDR_W-1:0] addr_d,
   input  logic              ba_d,
   output sdr_cmd_t          cmd_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic              ba_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= CMD_NOP;
         addr_q <= '0;
         ba_q   <= 1'b0;
      end else begin
         cmd_q  <= cmd_d;
         addr_q <= addr_d;
         ba_q   <= ba_d;
      end
   end

endmodule

// File: rtl/sdr_powerup_refresh.sv
module sdr_powerup_refresh
   import sdr_seq_pkg::*;
#(
   parameter int unsigned ADDR_W       = 11,
   parameter int unsigned DQM_W        = 2,
   parameter int unsigned AP_BIT       = 10,
   parameter logic [ADDR_W-1:0] MODE_WORD = 'h032,
   parameter int unsigned STABLE_CYC   = 25000,
   parameter int unsigned TRP_CYC      = 3,
   parameter int unsigned TRC_CYC      = 9,
   parameter int unsigned TRSC_CYC     = 2,
   parameter int unsigned INIT_REFS    = 2,
   parameter int unsigned REF_INTERVAL = 1950
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idle_i,
   output logic [3:0]        cmd_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              ba_o,
   output logic              cke_o,
   output logic [DQM_W-1:0]  dqm_o,
   output logic              ready_o,
   output logic              ref_req_o,
   output logic              ref_busy_o
);

   localparam int unsigned MAX_WAIT = max_u(max_u(STABLE_CYC, TRP_CYC), max_u(TRC_CYC, TRSC_CYC));
   localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 1);
   localparam int unsigned RW       = $clog2(INIT_REFS + 1);

   // elaboration-time parameter checks
   if (INIT_REFS < 2) begin : g_bad_refs
      $error("INIT_REFS must be at least 2");
   end
   if (STABLE_CYC < 1 || TRP_CYC < 1 || TRC_CYC < 1 || TRSC_CYC < 1) begin : g_bad_wait
      $error("every wait count must be at least 1");
   end
   if (AP_BIT >= ADDR_W) begin : g_bad_ap
      $error("AP_BIT must index into the address bus");
   end
   if (REF_INTERVAL <= TRC_CYC) begin : g_bad_interval
      $error("REF_INTERVAL must exceed TRC_CYC");
   end

   seq_state_t        state_q, state_d;
   logic [RW-1:0]     refs_q, refs_d;
   logic              ready_q, ready_d;
   logic              issue;
   logic              grant;
   logic              expire;
   logic              pending;
   logic [CNT_W-1:0]  limit;
   sdr_cmd_t          cmd_d;
   logic [ADDR_W-1:0] addr_d;
   logic              ba_d;

   sdr_gap_timer #(.CNT_W(CNT_W)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (issue),
      .limit   (limit),
      .expire  (expire)
   );

   sdr_refresh_pacer #(.REF_INTERVAL(REF_INTERVAL)) i_pacer (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (ready_q),
      .grant   (grant),
      .pending (pending)
   );

   sdr_cmd_reg #(.ADDR_W(ADDR_W)) i_cmd_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd_d  (cmd_d),
      .addr_d (addr_d),
      .ba_d   (ba_d),
      .cmd_q  (cmd_o),
      .addr_q (addr_o),
      .ba_q   (ba_o)
   );

   // wait length that belongs to the current step
   always_comb begin
      case (state_q)
         ST_SETTLE: limit = CNT_W'(STABLE_CYC);
         ST_TRP:    limit = CNT_W'(TRP_CYC);
         ST_TRSC:   limit = CNT_W'(TRSC_CYC);
         default:   limit = CNT_W'(TRC_CYC);
      endcase
   end

   always_comb begin
      state_d = state_q;
      refs_d  = refs_q;
      ready_d = ready_q;
      cmd_d   = CMD_NOP;
      addr_d  = '0;
      ba_d    = 1'b0;
      issue   = 1'b0;
      grant   = 1'b0;
      case (state_q)
         ST_SETTLE: begin
            if (expire) begin
               cmd_d          = CMD_PRE;
               addr_d[AP_BIT] = 1'b1;
               state_d        = ST_TRP;
               issue          = 1'b1;
            end
         end
         ST_TRP: begin
            if (expire) begin
               cmd_d   = CMD_REF;
               refs_d  = RW'(1);
               state_d = ST_TRC_INIT;
               issue   = 1'b1;
            end
         end
         ST_TRC_INIT: begin
            if (expire) begin
               issue = 1'b1;
               if (refs_q == RW'(INIT_REFS)) begin
                  cmd_d   = CMD_MRS;
                  addr_d  = MODE_WORD;
                  state_d = ST_TRSC;
               end else begin
                  cmd_d  = CMD_REF;
                  refs_d = refs_q + RW'(1);
               end
            end
         end
         ST_TRSC: begin
            if (expire) begin
               ready_d = 1'b1;
               state_d = ST_RUN;
               issue   = 1'b1;
            end
         end
         ST_RUN: begin
            if (pending && idle_i) begin
               cmd_d   = CMD_REF;
               grant   = 1'b1;
               issue   = 1'b1;
               state_d = ST_TRC_RUN;
            end
         end
         ST_TRC_RUN: begin
            if (expire) begin
               if (pending && idle_i) begin
                  cmd_d = CMD_REF;
                  grant = 1'b1;
                  issue = 1'b1;
               end else begin
                  state_d = ST_RUN;
               end
            end
         end
         default: state_d = ST_SETTLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_SETTLE;
         refs_q  <= '0;
         ready_q <= 1'b0;
      end else begin
         state_q <= state_d;
         refs_q  <= refs_d;
         ready_q <= ready_d;
      end
   end

   for (genvar i = 0; i < DQM_W; i++) begin : g_dqm
      assign dqm_o[i] = ~ready_q;
   end

   assign cke_o      = 1'b1;
   assign ready_o    = ready_q;
   assign ref_req_o  = pending;
   assign ref_busy_o = (state_q == ST_TRC_RUN);

endmodule

// File: rtl/sdr_seq_checker.sv
module sdr_seq_checker
   import sdr_seq_pkg::*;
#(
   parameter int unsigned ADDR_W    = 11,
   parameter int unsigned AP_BIT    = 10,
   parameter logic [ADDR_W-1:0] MODE_WORD = 'h032,
   parameter int unsigned TRP_CYC   = 3,
   parameter int unsigned TRC_CYC   = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              idle_i,
   input logic [3:0]        cmd_o,
   input logic [ADDR_W-1:0] addr_o,
   input logic              ba_o,
   input logic              ready_o,
   input logic              ref_req_o,
   input logic              ref_busy_o
);

   logic [15:0] gap_q;
   sdr_cmd_t    last_q;

   // edges since the previous non-NOP command and which one it was
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q  <= '0;
         last_q <= CMD_NOP;
      end else if (cmd_o != CMD_NOP) begin
         gap_q  <= 16'd1;
         last_q <= cmd_o;
      end else if (gap_q != 16'hFFFF) begin
         gap_q <= gap_q + 16'd1;
      end
   end

   a_r2_prea_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == CMD_PRE) |-> (addr_o[AP_BIT] && !ready_o));

   a_r3_ref_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == CMD_REF && last_q == CMD_PRE) |-> (gap_q >= 16'(TRP_CYC)));

   a_r4_ref_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == CMD_REF && last_q == CMD_REF) |-> (gap_q >= 16'(TRC_CYC)));

   a_r5_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == CMD_MRS) |-> (addr_o == MODE_WORD && !ba_o && last_q == CMD_REF
                              && gap_q >= 16'(TRC_CYC)));

   a_r6_ready_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |=> ready_o);

   a_r8_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req_o |=> (ref_req_o || cmd_o == CMD_REF));

   a_r9_grant_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == CMD_REF && ready_o) |-> ($past(idle_i) && $past(ref_req_o)));

   a_r9_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ref_busy_o |-> (cmd_o != CMD_PRE && cmd_o != CMD_MRS && ready_o));

endmodule

bind sdr_powerup_refresh sdr_seq_checker #(
   .ADDR_W    (ADDR_W),
   .AP_BIT    (AP_BIT),
   .MODE_WORD (MODE_WORD),
   .TRP_CYC   (TRP_CYC),
   .TRC_CYC   (TRC_CYC)
) i_seq_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .idle_i     (idle_i),
   .cmd_o      (cmd_o),
   .addr_o     (addr_o),
   .ba_o       (ba_o),
   .ready_o    (ready_o),
   .ref_req_o  (ref_req_o),
   .ref_busy_o (ref_busy_o)
);

// File: tb/test_sdr_powerup_refresh.sv
module test_sdr_powerup_refresh;

   localparam int unsigned ADDR_W = 11;
   localparam int unsigned DQM_W  = 2;
   localparam int unsigned AP_BIT = 10;
   localparam logic [ADDR_W-1:0] MODE = 11'h023;
   localparam int S    = 20;
   localparam int TRP  = 3;
   localparam int TRC  = 5;
   localparam int TRSC = 2;
   localparam int NREF = 3;
   localparam int IVL  = 40;

   localparam logic [3:0] NOP = 4'b0111;
   localparam logic [3:0] PRE = 4'b0010;
   localparam logic [3:0] REF = 4'b0001;
   localparam logic [3:0] MRS = 4'b0000;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              idle_i;
   logic [3:0]        cmd_o;
   logic [ADDR_W-1:0] addr_o;
   logic              ba_o;
   logic              cke_o;
   logic [DQM_W-1:0]  dqm_o;
   logic              ready_o;
   logic              ref_req_o;
   logic              ref_busy_o;

   int total = 0;
   int bad   = 0;
   int ecnt  = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   sdr_powerup_refresh #(
      .ADDR_W(ADDR_W), .DQM_W(DQM_W), .AP_BIT(AP_BIT), .MODE_WORD(MODE),
      .STABLE_CYC(S), .TRP_CYC(TRP), .TRC_CYC(TRC), .TRSC_CYC(TRSC),
      .INIT_REFS(NREF), .REF_INTERVAL(IVL)
   ) i_sdr_powerup_refresh (
      .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .cmd_o(cmd_o), .addr_o(addr_o),
      .ba_o(ba_o), .cke_o(cke_o), .dqm_o(dqm_o), .ready_o(ready_o),
      .ref_req_o(ref_req_o), .ref_busy_o(ref_busy_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      ecnt++;
   endtask

   // n-1 quiet edges then the expected command on the n-th
   task automatic gap_expect(input int n, input logic [3:0] exp, input string req);
      bit quiet = 1'b1;
      for (int k = 1; k < n; k++) begin
         step();
         if (cmd_o != NOP || ready_o) quiet = 1'b0;
      end
      step();
      chk(quiet, req, "NOP-only gap", 0, 1);
      chk(cmd_o == exp, req, "command after gap", cmd_o, exp);
   endtask

   task automatic t_reset();
      rst_n  = 1'b0;
      idle_i = 1'b1;
      repeat (3) @(negedge clk);
      chk(cmd_o == NOP, "R1", "cmd in reset", cmd_o, NOP);
      chk(cke_o == 1'b1 && dqm_o == '1, "R1", "cke/dqm in reset", {cke_o, dqm_o}, 3'b111);
      chk({ready_o, ref_req_o, ref_busy_o} == 3'b000, "R1", "status in reset",
          {ready_o, ref_req_o, ref_busy_o}, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_settle();
      bit quiet = 1'b1;
      for (int k = 1; k < S; k++) begin
         step();
         if (cmd_o != NOP || dqm_o != '1 || !cke_o) quiet = 1'b0;
      end
      chk(quiet, "R2", "settle window NOP with masks high", 0, 1);
      step();
      chk(cmd_o == PRE, "R2", "precharge-all at settle end", cmd_o, PRE);
      chk(addr_o[AP_BIT] == 1'b1, "R2", "all-bank flag", addr_o[AP_BIT], 1);
   endtask

   task automatic t_init();
      bit early = 1'b0;
      gap_expect(TRP, REF, "R3");
      for (int r = 2; r <= NREF; r++) gap_expect(TRC, REF, "R4");
      gap_expect(TRC, MRS, "R5");
      chk(addr_o == MODE && ba_o == 1'b0, "R5", "mode word on address", addr_o, MODE);
      for (int k = 1; k < TRSC; k++) begin
         step();
         if (ready_o) early = 1'b1;
      end
      chk(!early, "R6", "ready not early", early, 0);
      step();
      chk(ready_o == 1'b1, "R6", "ready after mode wait", ready_o, 1);
      chk(dqm_o == '0, "R6", "masks low when ready", dqm_o, 0);
      ecnt = 0;
   endtask

   task automatic t_first_refresh();
      bit ok = 1'b1;
      idle_i = 1'b0;
      for (int k = 1; k < IVL; k++) begin
         step();
         if (ref_req_o || cmd_o != NOP) ok = 1'b0;
      end
      chk(ok, "R7", "no request before interval", 0, 1);
      step();
      chk(ref_req_o == 1'b1, "R7", "request at interval end", ref_req_o, 1);
      ok = 1'b1;
      for (int k = 0; k < 10; k++) begin
         step();
         if (!ref_req_o || cmd_o != NOP) ok = 1'b0;
      end
      chk(ok, "R8", "request held while not idle", 0, 1);
      idle_i = 1'b1;
      step();
      idle_i = 1'b0;
      chk(cmd_o == REF, "R9", "refresh on grant", cmd_o, REF);
      chk(ref_req_o == 1'b0 && ref_busy_o == 1'b1, "R9", "req clear, busy set",
          {ref_req_o, ref_busy_o}, 2'b01);
      ok = 1'b1;
      for (int k = 1; k < TRC; k++) begin
         step();
         if (!ref_busy_o || cmd_o != NOP) ok = 1'b0;
      end
      chk(ok, "R9", "busy window quiet", 0, 1);
      step();
      chk(ref_busy_o == 1'b0, "R9", "busy ends after row cycle", ref_busy_o, 0);
   endtask

   task automatic t_second_interval();
      bit ok = 1'b1;
      while (ecnt < 2 * IVL - 1) begin
         step();
         if (ref_req_o) ok = 1'b0;
      end
      chk(ok, "R7", "quiet until second interval", 0, 1);
      step();
      chk(ref_req_o == 1'b1, "R7", "second request on schedule", ref_req_o, 1);
   endtask

   task automatic t_coincide();
      bit ok = 1'b1;
      while (ecnt < 3 * IVL - 1) begin
         step();
         if (!ref_req_o || cmd_o != NOP) ok = 1'b0;
      end
      chk(ok, "R8", "long hold keeps request", 0, 1);
      idle_i = 1'b1;
      step();
      idle_i = 1'b0;
      chk(cmd_o == REF, "R10", "grant on interval edge", cmd_o, REF);
      chk(ref_req_o == 1'b1, "R10", "new request survives grant", ref_req_o, 1);
      for (int k = 1; k <= TRC; k++) step();
      chk(ref_busy_o == 1'b0, "R9", "busy cleared", ref_busy_o, 0);
      step();
      idle_i = 1'b1;
      step();
      chk(cmd_o == REF, "R10", "second grant serves new request", cmd_o, REF);
      chk(ref_req_o == 1'b0, "R10", "request cleared", ref_req_o, 0);
      ok = 1'b1;
      for (int k = 0; k < TRC + 8; k++) begin
         step();
         if (cmd_o != NOP || ref_req_o) ok = 1'b0;
      end
      chk(ok, "R11", "idle without request issues nothing", 0, 1);
      chk(ready_o == 1'b1, "R6", "ready still high", ready_o, 1);
      idle_i = 1'b0;
   endtask

   initial begin
      t_reset();
      t_settle();
      t_init();
      t_first_refresh();
      t_second_interval();
      t_coincide();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule